// File: doc/BRIEF.md
# Depth-Chainable FIFO Slice with Write Token

This block is one storage slice of a first-in/first-out buffer that can run alone or be chained with identical slices to build a deeper buffer. Each slice has its own RAM, write and read pointers, and occupancy flags. It also has three pins whose meaning depends on the mode: an expansion input, an expansion output, and a first-load/retransmit input.

The mode is chosen by the level on `exp_in` while reset is held:
- **Stand-alone mode.** `exp_in` is high during reset. `first_load_rt` then rewinds the read side so that stored data can be replayed. `exp_out` reports that the slice is more than half full.
- **Chained mode.** `exp_in` is low during reset. The slices form a ring, with each `exp_out` wired to the next slice's `exp_in`, and a single write token moves around the ring. The slice whose `first_load_rt` is high during reset starts with the token. The write bus is shared by all slices, but only the token holder stores words. When the holder writes its last RAM location, it raises `exp_out` for that same cycle and gives up the token. At the same clock edge the next slice takes it.

Reads stay local to each slice.

Top module: `exp_fifo_slice`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers clear. After reset the slice shows `empty`=1, `full`=0 and `exp_out`=0. In stand-alone mode `wr_owner`=1.
- R2: In stand-alone mode, `exp_out` is 1 exactly when the slice holds more than DEPTH/2 words.
- R3: In stand-alone mode, a cycle with `first_load_rt`=1 moves the read position back to RAM location 0. The next reads then return the stored words again, starting from the first word written.
- R4: In chained mode, `wr_owner` is 1 after reset only on the slice that had `first_load_rt`=1 during reset. Every other slice has `wr_owner`=0.
- R5: A write (`wr_en`=1 with the slice not full) is stored only while `wr_owner`=1. In a ring, consecutive words therefore fill one slice after another, in ring order.
- R6: In chained mode, `exp_out` is 1 during exactly the one cycle in which a write to RAM location DEPTH-1 is accepted. After that clock edge the slice holds no token, unless its own `exp_in` was high in that cycle.
- R7: In chained mode, a slice that sees `exp_in`=1 at a clock edge holds the token after that edge.
- R8: In chained mode, `first_load_rt` has no effect after reset. The read order continues unchanged.
- R9: A write while `full`=1 stores nothing, and a read while `empty`=1 does not move the read position. Read data appears on `rd_data` in the cycle after `rd_en` is sampled.
- R10: `almost` is 1 when the slice holds fewer than DEPTH/8 words or more than DEPTH-DEPTH/8 words, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; mode and token are sampled while it is low |
| wr_en | input | 1 | Write request |
| wr_data | input | W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | W | Registered read word |
| first_load_rt | input | 1 | Chained: first-owner mark during reset; stand-alone: retransmit |
| exp_in | input | 1 | Chained: token arrival; level during reset selects the mode |
| exp_out | output | 1 | Chained: token hand-off pulse; stand-alone: more than half full |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| almost | output | 1 | Occupancy in the lowest or highest eighth |
| wr_owner | output | 1 | Slice currently accepts writes |

## Verification
The bench first checks the hand-off cycle itself. If the pulse were registered, no slice would hold the token for one cycle and word DEPTH would be lost. If the pulse fired one write early or late, the words would split across slices at the wrong place, and reading each slice back would show it. It also writes once more after the ring has wrapped back to a full first slice, to confirm that a full owner silently drops the word. In chained mode it asserts `first_load_rt` in the middle of reading; a design that still decoded retransmit there would replay old words. Finally it compares the half-full and almost thresholds at the exact occupancy on each side of the boundary, where an off-by-one would flip the flag.

// File: rtl/exp_fifo_slice.sv
module exp_fifo_slice #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         first_load_rt,
  input  logic         exp_in,
  output logic         exp_out,
  output logic         empty,
  output logic         full,
  output logic         almost,
  output logic         wr_owner
);
  localparam int AW     = $clog2(DEPTH);
  localparam int EIGHTH = DEPTH / 8;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr, count;
  logic         single_q, token_q;
  logic         wr_acc, rd_acc, rt_hit, last_slot, half;

  assign count     = wptr - rptr;
  assign empty     = (count == '0);
  assign full      = (count == (AW+1)'(DEPTH));
  assign half      = (count > (AW+1)'(DEPTH / 2));
  assign almost    = (count < (AW+1)'(EIGHTH)) || (count > (AW+1)'(DEPTH - EIGHTH));
  assign wr_owner  = single_q | token_q;
  assign wr_acc    = rst_n & wr_en & ~full & wr_owner;
  assign rd_acc    = rst_n & rd_en & ~empty;
  assign rt_hit    = single_q & first_load_rt;
  assign last_slot = (wptr[AW-1:0] == AW'(DEPTH - 1));
  assign exp_out   = !rst_n ? 1'b0 : (single_q ? half : (wr_acc & last_slot));

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      rd_data  <= '0;
      single_q <= exp_in;
      token_q  <= ~exp_in & first_load_rt;
    end else begin
      if (wr_acc) wptr <= wptr + 1'b1;
      if (rt_hit) rptr <= '0;
      else if (rd_acc) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr[AW-1:0]];
      end
      if (!single_q) begin
        if (exp_in) token_q <= 1'b1;
        else if (wr_acc && last_slot) token_q <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (AW+1)'(DEPTH)); // R9
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (wptr == $past(wptr))); // R9
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rt_hit) |=> (rptr == $past(rptr))); // R9
  AST_NO_TOKEN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && !token_q) |=> (wptr == $past(wptr))); // R5
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && exp_out) |=> !exp_out); // R6
  AST_TOKEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && exp_out && !exp_in) |=> !token_q); // R6
  AST_TOKEN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && exp_in) |=> token_q); // R7
  AST_RT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_q && !(rd_en && !empty)) |=> (rptr == $past(rptr))); // R8
endmodule

// File: tb/sim_exp_fifo_slice.sv
`timescale 1ns/1ps
module sim_exp_fifo_slice;
  localparam int W = 9;
  localparam int D = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic wr0 = 0, wrr = 0, rd0 = 0, rd1 = 0, rd2 = 0, rd3 = 0, rt0 = 0, fl1 = 1;
  logic [W-1:0] wd0 = '0, wdr = '0;
  logic [W-1:0] q0, q1, q2, q3;
  logic x0, x1, x2, x3;
  logic e0, e1, e2, e3, f0, f1, f2, f3, a0, a1, a2, a3, o0, o1, o2, o3;
  int vectors = 0, fails = 0;

  exp_fifo_slice #(.W(W), .DEPTH(D)) u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr0), .wr_data(wd0),
    .rd_en(rd0), .rd_data(q0), .first_load_rt(rt0), .exp_in(1'b1), .exp_out(x0),
    .empty(e0), .full(f0), .almost(a0), .wr_owner(o0));
  exp_fifo_slice #(.W(W), .DEPTH(D)) u1 (.clk(clk), .rst_n(rst_n), .wr_en(wrr), .wr_data(wdr),
    .rd_en(rd1), .rd_data(q1), .first_load_rt(fl1), .exp_in(x3), .exp_out(x1),
    .empty(e1), .full(f1), .almost(a1), .wr_owner(o1));
  exp_fifo_slice #(.W(W), .DEPTH(D)) u2 (.clk(clk), .rst_n(rst_n), .wr_en(wrr), .wr_data(wdr),
    .rd_en(rd2), .rd_data(q2), .first_load_rt(1'b0), .exp_in(x1), .exp_out(x2),
    .empty(e2), .full(f2), .almost(a2), .wr_owner(o2));
  exp_fifo_slice #(.W(W), .DEPTH(D)) u3 (.clk(clk), .rst_n(rst_n), .wr_en(wrr), .wr_data(wdr),
    .rd_en(rd3), .rd_data(q3), .first_load_rt(1'b0), .exp_in(x2), .exp_out(x3),
    .empty(e3), .full(f3), .almost(a3), .wr_owner(o3));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; fl1 = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; fl1 = 0;
  endtask

  task automatic push0(input logic [W-1:0] d);
    @(negedge clk); wr0 = 1; wd0 = d;
    @(negedge clk); wr0 = 0;
  endtask

  task automatic pushr(input logic [W-1:0] d, output logic [2:0] pulses);
    @(negedge clk); wrr = 1; wdr = d;
    #1 pulses = {x3, x2, x1};
    @(negedge clk); wrr = 0;
  endtask

  task automatic pop(input int s, output logic [W-1:0] d);
    @(negedge clk);
    case (s) 0: rd0 = 1; 1: rd1 = 1; 2: rd2 = 1; default: rd3 = 1; endcase
    @(negedge clk);
    rd0 = 0; rd1 = 0; rd2 = 0; rd3 = 0;
    case (s) 0: d = q0; 1: d = q1; 2: d = q2; default: d = q3; endcase
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(e0 && !f0 && !x0 && o0, "R1 u0 reset flags", {e0, f0, x0, o0}, 4'b1001);
    chk(e1 && e2 && e3 && !f1 && !x1 && !x2 && !x3, "R1 ring reset flags", {e1, e2, e3, x1}, 4'b1110);
    chk({o1, o2, o3} == 3'b100, "R4 initial owner", {o1, o2, o3}, 3'b100);
  endtask

  task automatic t_retransmit();
    logic [W-1:0] d;
    do_reset();
    for (int i = 0; i < 4; i++) push0(W'(9'h0A0 + i));
    for (int i = 0; i < 2; i++) begin
      pop(0, d); chk(d == W'(9'h0A0 + i), "R3 pre-rt read", d, 9'h0A0 + i);
    end
    @(negedge clk); rt0 = 1;
    @(negedge clk); rt0 = 0;
    for (int i = 0; i < 4; i++) begin
      pop(0, d); chk(d == W'(9'h0A0 + i), "R3 replay read", d, 9'h0A0 + i);
    end
    chk(e0 == 1'b1, "R3 empty after replay", e0, 1);
  endtask

  task automatic t_single_flags();
    logic [W-1:0] d;
    do_reset();
    for (int i = 1; i <= D; i++) begin
      push0(W'(9'h100 + i));
      chk(x0 == (i > D/2), "R2 half flag", x0, int'(i > D/2));
      chk(a0 == ((i < D/8) || (i > D - D/8)), "R10 almost flag", a0, int'((i < D/8) || (i > D - D/8)));
      chk(f0 == (i == D), "R9 full flag", f0, int'(i == D));
    end
    push0(9'h1FF);
    chk(f0 == 1'b1, "R9 full after extra write", f0, 1);
    for (int i = 1; i <= D; i++) begin
      pop(0, d); chk(d == W'(9'h100 + i), "R9 data after overflow try", d, 9'h100 + i);
    end
    chk(e0 == 1'b1, "R9 empty after drain", e0, 1);
    pop(0, d);
    chk(e0 == 1'b1, "R9 empty after underflow read", e0, 1);
    push0(9'h055);
    pop(0, d);
    chk(d == 9'h055, "R9 read pointer held on empty", d, 9'h055);
  endtask

  task automatic t_ring();
    logic [2:0] p;
    logic [W-1:0] d;
    do_reset();
    for (int i = 0; i < 3*D; i++) begin
      chk($onehot({o1, o2, o3}), "R5 one owner", {o1, o2, o3}, 1);
      pushr(W'(i), p);
      chk(p == ((i == D-1) ? 3'b001 : (i == 2*D-1) ? 3'b010 : (i == 3*D-1) ? 3'b100 : 3'b000),
          "R6 hand-off pulse", p, i);
      if (i == D-1) chk({o1, o2, o3} == 3'b010, "R7 token to u2", {o1, o2, o3}, 3'b010);
      if (i == 2*D-1) chk({o1, o2, o3} == 3'b001, "R7 token to u3", {o1, o2, o3}, 3'b001);
    end
    chk({o1, o2, o3} == 3'b100, "R7 token back to u1", {o1, o2, o3}, 3'b100);
    chk(f1 && f2 && f3, "R9 ring full", {f1, f2, f3}, 3'b111);
    pushr(9'h1EE, p);
    chk(p == 3'b000, "R9 no pulse on full owner", p, 0);
    for (int i = 0; i < 5; i++) begin
      pop(1, d); chk(d == W'(i), "R5 u1 words", d, i);
    end
    @(negedge clk); fl1 = 1;
    @(negedge clk); fl1 = 0;
    for (int i = 5; i < D; i++) begin
      pop(1, d); chk(d == W'(i), "R8 u1 order kept", d, i);
    end
    chk(e1 == 1'b1, "R9 u1 dropped extra word", e1, 1);
    for (int i = 0; i < D; i++) begin
      pop(2, d); chk(d == W'(D + i), "R5 u2 words", d, D + i);
    end
    for (int i = 0; i < D; i++) begin
      pop(3, d); chk(d == W'(2*D + i), "R5 u3 words", d, 2*D + i);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_retransmit();
    t_single_flags();
    t_ring();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule